// File: doc/BRIEF.md
# Serial EEPROM Read Controller

This block is a read-only master for a three-wire serial EEPROM that is addressed in 16-bit words. It drives chip select, a shift clock and a serial command line, and samples the device's serial output. A read is requested with a one-cycle start pulse and a word address. The block sends a read command and shifts 16 data bits back in. It then presents the word together with a one-cycle completion pulse.

Straight after reset the block runs an automatic load. It first reads word 0 using an 8-bit address field and compares the result with the signature 0x8129. A match selects 8-bit addressing; anything else selects 6-bit addressing. With the chosen width it reads words 7, 8 and 9 and assembles a 48-bit station address from them. User reads are refused until this load has finished. Every half period of the serial clock lasts `HALF_CYC` system clocks, which sets the serial bit rate.

Top module: `mw_rom_reader`

## Requirements
- R1: While reset is held, `ee_cs`, `ee_sk`, `ee_di`, `rd_done` and `station_valid` are 0, and `busy` is 1.
- R2: The first access after reset reads word 0 with an 8-bit address field. `addr8_mode` becomes 1 if that word equals 0x8129, and 0 otherwise.
- R3: The automatic load then reads words 7, 8 and 9 at the selected width. When it finishes, `station_addr` = {word9, word8, word7}, so the low byte of word 7 is bits 7:0. `station_valid` then rises and stays high until reset. `busy` stays high until the load has finished.
- R4: A read command consists of a start bit 1, then the bits 1 and 0, then the address with its most significant bit first. The whole command equals (6 << W) | address, where W is 6 or 8. In 6-bit mode only `rd_addr[5:0]` is sent.
- R5: A frame is a fixed sequence of steps, each `HALF_CYC` clocks long. In the order shown, as {cs,sk,di}, the steps are:
  - idle 000;
  - select 100;
  - for each command bit b: 10b, then 11b;
  - one gap step 100;
  - 16 pairs of 110 and 100;
  - a final step 000.
- R6: The device output is sampled at the end of each of the 16 data high steps. The first sample is the most significant bit of `rd_data`.
- R7: `rd_done` is high for exactly one cycle, in the clock after the final step. `rd_data` carries the new word in that cycle and holds it until the next read completes.
- R8: `rd_start` has no effect while `busy` is 1. This covers both the automatic load and a user frame in progress.
- R9: A start pulse that is accepted at a clock edge begins the idle step in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | One-cycle read request |
| rd_addr | input | 8 | Word address of the read |
| rd_data | output | 16 | Last word read |
| rd_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Automatic load or frame in progress |
| station_addr | output | 48 | Station address from words 7 to 9 |
| station_valid | output | 1 | Station address loaded |
| addr8_mode | output | 1 | 1 when 8-bit addressing was detected |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial command to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The bench pairs a bit-level EEPROM model with a cycle-exact pin reference and compares them on every clock of each user frame. Any error in step length, command bit order or the gap step would therefore show up as a pin mismatch. Both device widths are exercised:
- An 8-bit device carries the signature, so a wrong width choice or probe width would misalign every later data word.
- A 6-bit device answers the 8-bit probe with a shifted word, so accepting it as wide would corrupt the station address.

Further cases target specific failure modes:
- A start pulse issued mid-frame and during the load must leave the frame untouched. A design that accepted it would restart or emit an extra `rd_done`.
- Words 0x8001 and 0xFFFF catch sampling on the wrong edge, which would drop or shift the end bits.
- Address 0xC5 in 6-bit mode catches a missing truncation.

// File: rtl/mw_rom_pkg.sv
package mw_rom_pkg;

    localparam int            WORD_W   = 16;
    localparam int            CMD_W    = 11;
    localparam logic [2:0]    READ_OP  = 3'b110;
    localparam logic [15:0]   WIDE_SIG = 16'h8129;

    typedef enum logic [3:0] {
        E_IDLE, E_PRE, E_SEL, E_CLO, E_CHI, E_GAP, E_DHI, E_DLO, E_FIN
    } eng_state_t;

    typedef enum logic [2:0] {
        Q_PROBE, Q_W7, Q_W8, Q_W9, Q_READY
    } seq_state_t;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } ee_pins_t;

    function automatic logic [WORD_W-1:0] build_cmd(input logic aw8, input logic [7:0] a);
        logic [CMD_W-1:0] c;
        c = aw8 ? {READ_OP, a} : {2'b00, READ_OP, a[5:0]};
        return WORD_W'(c);
    endfunction

    function automatic logic [3:0] top_cmd_bit(input logic aw8);
        return aw8 ? 4'd10 : 4'd8;
    endfunction

endpackage

// File: rtl/mw_half_timer.sv
module mw_half_timer #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || cnt == LAST) cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

    p_tick_needs_run_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));
endmodule

// File: rtl/mw_frame_engine.sv
module mw_frame_engine
    import mw_rom_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        addr,
    input  logic              aw8,
    input  logic              tick,
    input  logic              ee_do,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] word,
    output ee_pins_t          pins
);
    eng_state_t        st;
    logic [3:0]        bi;
    logic [WORD_W-1:0] cmd_q;
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= E_IDLE;
            bi    <= '0;
            cmd_q <= '0;
            shreg <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == E_IDLE) begin
                if (start) begin
                    cmd_q <= build_cmd(aw8, addr);
                    bi    <= top_cmd_bit(aw8);
                    st    <= E_PRE;
                end
            end else if (tick) begin
                unique case (st)
                    E_PRE: st <= E_SEL;
                    E_SEL: st <= E_CLO;
                    E_CLO: st <= E_CHI;
                    E_CHI: begin
                        if (bi == 4'd0) st <= E_GAP;
                        else begin bi <= bi - 4'd1; st <= E_CLO; end
                    end
                    E_GAP: begin bi <= 4'(WORD_W - 1); st <= E_DHI; end
                    E_DHI: begin shreg <= {shreg[WORD_W-2:0], ee_do}; st <= E_DLO; end
                    E_DLO: begin
                        if (bi == 4'd0) st <= E_FIN;
                        else begin bi <= bi - 4'd1; st <= E_DHI; end
                    end
                    E_FIN: begin st <= E_IDLE; done <= 1'b1; end
                    default: st <= E_IDLE;
                endcase
            end
        end
    end

    assign busy    = (st != E_IDLE);
    assign word    = shreg;
    assign pins.cs = (st == E_SEL) || (st == E_CLO) || (st == E_CHI) ||
                     (st == E_GAP) || (st == E_DHI) || (st == E_DLO);
    assign pins.sk = (st == E_CHI) || (st == E_DHI);
    assign pins.di = ((st == E_CLO) || (st == E_CHI)) && cmd_q[bi];

    p_sk_inside_cs_r5: assert property (@(posedge clk) disable iff (rst)
        pins.sk |-> pins.cs);
    p_sk_high_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (HALF_CYC > 1 && $rose(pins.sk)) |=> pins.sk);
    p_di_steady_high_r4: assert property (@(posedge clk) disable iff (rst)
        pins.sk |=> (!pins.sk || $stable(pins.di)));
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_after_cs_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!pins.cs && !busy));
endmodule

// File: rtl/mw_load_seq.sv
module mw_load_seq
    import mw_rom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic [7:0]        rd_addr,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [WORD_W-1:0] eng_word,
    output logic              eng_start,
    output logic [7:0]        eng_addr,
    output logic              eng_aw8,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_done,
    output logic              busy,
    output logic [47:0]       station_addr,
    output logic              station_valid,
    output logic              addr8_mode
);
    seq_state_t        state;
    logic              issued;
    logic [WORD_W-1:0] rd_q;

    wire ready = (state == Q_READY);

    always_comb begin
        eng_start = ready ? (rd_start && !eng_busy) : (!issued && !eng_busy);
        eng_aw8   = (state == Q_PROBE) ? 1'b1 : addr8_mode;
        unique case (state)
            Q_PROBE: eng_addr = 8'd0;
            Q_W7:    eng_addr = 8'd7;
            Q_W8:    eng_addr = 8'd8;
            Q_W9:    eng_addr = 8'd9;
            default: eng_addr = rd_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= Q_PROBE;
            issued        <= 1'b0;
            addr8_mode    <= 1'b0;
            station_addr  <= '0;
            station_valid <= 1'b0;
            rd_q          <= '0;
        end else begin
            if (eng_start) issued <= 1'b1;
            if (eng_done) begin
                issued <= 1'b0;
                unique case (state)
                    Q_PROBE: begin addr8_mode <= (eng_word == WIDE_SIG); state <= Q_W7; end
                    Q_W7:    begin station_addr[15:0]  <= eng_word; state <= Q_W8; end
                    Q_W8:    begin station_addr[31:16] <= eng_word; state <= Q_W9; end
                    Q_W9:    begin
                        station_addr[47:32] <= eng_word;
                        station_valid       <= 1'b1;
                        state               <= Q_READY;
                    end
                    default: rd_q <= eng_word;
                endcase
            end
        end
    end

    assign rd_done = eng_done && ready;
    assign rd_data = rd_done ? eng_word : rd_q;
    assign busy    = !ready || eng_busy;

    p_station_hold_r3: assert property (@(posedge clk) disable iff (rst)
        station_valid |=> (station_valid && $stable(station_addr)));
    p_busy_until_loaded_r3: assert property (@(posedge clk) disable iff (rst)
        !station_valid |-> busy);
    p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_done |-> $stable(rd_data));
    p_no_done_in_load_r8: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> station_valid);
    p_width_fixed_r2: assert property (@(posedge clk) disable iff (rst)
        station_valid |=> $stable(addr8_mode));
endmodule

// File: rtl/mw_rom_reader.sv
module mw_rom_reader
    import mw_rom_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_start,
    input  logic [7:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic        rd_done,
    output logic        busy,
    output logic [47:0] station_addr,
    output logic        station_valid,
    output logic        addr8_mode,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_di,
    input  logic        ee_do
);
    logic              eng_start, eng_busy, eng_done, eng_aw8, tick;
    logic [7:0]        eng_addr;
    logic [WORD_W-1:0] eng_word;
    ee_pins_t          pins;

    mw_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk(clk), .rst(rst), .run(eng_busy), .tick(tick)
    );

    mw_frame_engine #(.HALF_CYC(HALF_CYC)) u_engine (
        .clk(clk), .rst(rst), .start(eng_start), .addr(eng_addr), .aw8(eng_aw8),
        .tick(tick), .ee_do(ee_do), .busy(eng_busy), .done(eng_done),
        .word(eng_word), .pins(pins)
    );

    mw_load_seq u_seq (
        .clk(clk), .rst(rst), .rd_start(rd_start), .rd_addr(rd_addr),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_word(eng_word),
        .eng_start(eng_start), .eng_addr(eng_addr), .eng_aw8(eng_aw8),
        .rd_data(rd_data), .rd_done(rd_done), .busy(busy),
        .station_addr(station_addr), .station_valid(station_valid),
        .addr8_mode(addr8_mode)
    );

    assign ee_cs = pins.cs;
    assign ee_sk = pins.sk;
    assign ee_di = pins.di;
endmodule

// File: tb/mw_rom_reader_bench.sv
module mw_rom_reader_bench;
    localparam int H = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        rd_start = 1'b0;
    logic [7:0]  rd_addr  = 8'h00;
    logic [15:0] rd_data;
    logic        rd_done, busy, station_valid, addr8_mode;
    logic [47:0] station_addr;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do_r = 1'b0;

    mw_rom_reader #(.HALF_CYC(H)) u_mw_rom_reader (
        .clk(clk), .rst(rst), .rd_start(rd_start), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_done(rd_done), .busy(busy),
        .station_addr(station_addr), .station_valid(station_valid),
        .addr8_mode(addr8_mode), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .ee_do(ee_do_r)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    // device model and pin monitor
    logic [15:0] mem [256];
    int          dev_aw = 8;
    logic        dsk_q = 1'b0, dcs_q = 1'b0;
    int          dcnt = 0, daddr = 0, mcnt = 0, nframes = 0, done_cnt = 0;
    logic [15:0] dcmd = '0;
    logic [31:0] msr = '0;
    logic [31:0] fsr [16];
    int          fn  [16];

    always @(posedge clk) begin : dev_model
        int k;
        dsk_q <= ee_sk;
        dcs_q <= ee_cs;
        if (rd_done) done_cnt <= done_cnt + 1;
        if (dcs_q && !ee_cs) begin
            if (nframes < 16) begin fsr[nframes] <= msr; fn[nframes] <= mcnt; end
            nframes <= nframes + 1;
        end
        if (!ee_cs) begin
            dcnt <= 0; ee_do_r <= 1'b0; msr <= '0; mcnt <= 0;
        end else if (ee_sk && !dsk_q) begin
            k = dcnt + 1;
            dcnt <= k;
            msr  <= {msr[30:0], ee_di};
            mcnt <= mcnt + 1;
            if (k <= 3 + dev_aw) dcmd <= {dcmd[14:0], ee_di};
            if (k == 3 + dev_aw) daddr <= int'({dcmd[14:0], ee_di}) & ((1 << dev_aw) - 1);
            if (k > 3 + dev_aw && k <= 19 + dev_aw) ee_do_r <= mem[daddr][19 + dev_aw - k];
            else ee_do_r <= 1'b0;
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_cmd(input int aw, input int a);
        return (6 << aw) | (a & ((1 << aw) - 1));
    endfunction

    task automatic fill_mem(input logic [15:0] w0);
        for (int a = 0; a < 256; a++) mem[a] = 16'((a * 257) ^ 16'h5A3C);
        mem[0]     = w0;
        mem[7]     = 16'h2211;
        mem[8]     = 16'h4433;
        mem[9]     = 16'h6655;
        mem[8'h2A] = 16'h8001;
        mem[8'hFF] = 16'hFFFF;
        mem[8'h3F] = 16'h0001;
    endtask

    task automatic reset_and_load(input int exp_aw);
        int base;
        int d0;
        int t;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk({ee_cs, ee_sk, ee_di} == 3'b000, "R1", "pins in reset", {ee_cs, ee_sk, ee_di}, 0);
        chk(!rd_done && !station_valid && busy, "R1", "flags in reset",
            {rd_done, station_valid, busy}, 3'b001);
        base = nframes;
        d0   = done_cnt;
        rst  = 1'b0;
        repeat (20) @(negedge clk);
        rd_start = 1'b1; rd_addr = 8'h33;       // R8: ignored during load
        @(negedge clk);
        rd_start = 1'b0;
        t = 0;
        while (!station_valid && t < 5000) begin @(negedge clk); t++; end
        chk(station_valid, "R3", "load finished", station_valid, 1);
        chk(!busy, "R3", "busy after load", busy, 0);
        chk(addr8_mode == (exp_aw == 8), "R2", "width select", addr8_mode, exp_aw == 8);
        chk(station_addr == {mem[9], mem[8], mem[7]}, "R3", "station address",
            station_addr, {mem[9], mem[8], mem[7]});
        chk(nframes - base == 4, "R8", "frames during load", nframes - base, 4);
        chk(done_cnt == d0, "R8", "no done during load", done_cnt - d0, 0);
        chk(fsr[base] >> 16 == 32'(exp_cmd(8, 0)) && fn[base] == 27, "R2", "probe command",
            fsr[base] >> 16, exp_cmd(8, 0));
        for (int i = 1; i < 4; i++)
            chk(fsr[base + i] >> 16 == 32'(exp_cmd(exp_aw, 6 + i)) && fn[base + i] == 19 + exp_aw,
                "R4", "load command", fsr[base + i] >> 16, exp_cmd(exp_aw, 6 + i));
        repeat (4) @(negedge clk);
    endtask

    task automatic user_read(input logic [7:0] a, input int aw, input bit poke);
        logic [2:0] q[$];
        int   n;
        int   cmd;
        int   bad;
        logic [2:0] bad_act, bad_exp;
        logic [15:0] expw;
        n    = 3 + aw;
        cmd  = exp_cmd(aw, a);
        expw = mem[int'(a) & ((1 << aw) - 1)];
        for (int j = 0; j < H; j++) q.push_back(3'b000);
        for (int j = 0; j < H; j++) q.push_back(3'b100);
        for (int b = n - 1; b >= 0; b--) begin
            for (int j = 0; j < H; j++) q.push_back({2'b10, cmd[b]});
            for (int j = 0; j < H; j++) q.push_back({2'b11, cmd[b]});
        end
        for (int j = 0; j < H; j++) q.push_back(3'b100);
        for (int d = 0; d < 16; d++) begin
            for (int j = 0; j < H; j++) q.push_back(3'b110);
            for (int j = 0; j < H; j++) q.push_back(3'b100);
        end
        for (int j = 0; j < H; j++) q.push_back(3'b000);

        @(negedge clk);
        rd_start = 1'b1; rd_addr = a;
        @(posedge clk);
        bad = 0; bad_act = '0; bad_exp = '0;
        for (int i = 0; i < q.size(); i++) begin
            @(negedge clk);
            if ({ee_cs, ee_sk, ee_di} !== q[i] || rd_done) begin
                if (bad == 0) begin bad_act = {ee_cs, ee_sk, ee_di}; bad_exp = q[i]; end
                bad++;
            end
            if (i == 4) chk(busy, "R8", "busy in frame", busy, 1);
            if (poke && i == 10) begin rd_start = 1'b1; rd_addr = ~a; end
            else rd_start = 1'b0;
        end
        chk(bad == 0, "R5", "pin sequence per clock", bad_act, bad_exp);
        @(negedge clk);
        chk(rd_done, "R7", "done pulse", rd_done, 1);
        chk(rd_data == expw, "R6", "read word", rd_data, expw);
        @(negedge clk);
        chk(!rd_done, "R7", "done single cycle", rd_done, 0);
        repeat (6) @(negedge clk);
        chk(rd_data == expw, "R7", "data held", rd_data, expw);
        chk(!ee_cs && !busy, "R8", "no extra frame", {ee_cs, busy}, 0);
    endtask

    initial begin
        // wide device carrying the signature
        dev_aw = 8;
        fill_mem(16'h8129);
        reset_and_load(8);
        user_read(8'h2A, 8, 1'b0);   // R6 end bits
        user_read(8'hA5, 8, 1'b1);   // R8 mid-frame start, R9 timing
        user_read(8'hFF, 8, 1'b0);   // R4 all-ones address
        // narrow device: probe misreads, 6-bit mode chosen
        dev_aw = 6;
        fill_mem(16'h1234);
        reset_and_load(6);
        user_read(8'hC5, 6, 1'b0);   // R4 truncation to 6 bits
        user_read(8'h3F, 6, 1'b0);
        finished = 1;
        summary();
        $finish;
    end
endmodule